// File: doc/BRIEF.md
# Multiplexer Logic Cell

This block is a configurable logic cell that realises any Boolean function of `NVARS` input variables. It does so with a multiplexer of `2^(NVARS-1)` inputs rather than a full lookup table. The upper `NVARS-1` variables form a binary index that picks one multiplexer input, or leg. Each leg takes its value from one of four sources: constant 0, constant 1, the lowest variable, or the complement of the lowest variable. For any fixed index, the two truth-table rows that differ only in the lowest variable always reduce to one of these four cases. Two configuration bits per leg are therefore enough.

The configuration is written as one whole word on a clock edge when the write strobe is high. The output is purely combinational in the variables and the enable. The cell holds an asynchronous active-low reset. An internal synchroniser releases that reset on a clock edge. While reset is held, every leg code is zero, so the cell computes the constant 0.

With the default `NVARS = 4`, there are eight legs and a 16-bit configuration word.

Top module: `mxcell_top`

## Requirements
- R1: While reset is active, and after it is released, every leg code is 2'b00 until the first write. The output is then 0 for every variable combination.
- R2: A selected leg with code 2'b00 drives the output to 0.
- R3: A selected leg with code 2'b01 drives the output to 1.
- R4: A selected leg with code 2'b10 drives the output to the value of `vars_in[0]`.
- R5: A selected leg with code 2'b11 drives the output to the inverse of `vars_in[0]`.
- R6: The selected leg index is the unsigned number `vars_in[NVARS-1:1]`, with `vars_in[NVARS-1]` as the most significant bit. Leg k is held in configuration bits [2k+1:2k].
- R7: The word on `cfg_wdata` replaces the whole configuration on a rising clock edge where `cfg_we` is 1. The new function is visible after that edge. While `cfg_we` is 0, the configuration does not change, whatever `cfg_wdata` carries.
- R8: While `en` is 0, the output is 0. Toggling `en` leaves the configuration unchanged.
- R9: The output follows changes of `vars_in` and `en` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 2*2^(NVARS-1) | New configuration, two bits per leg |
| vars_in | input | NVARS | Function variables; bit 0 is the data variable |
| en | input | 1 | Active-high output enable |
| f_out | output | 1 | Function result |

## Verification
The hardest case to reach from the ports is a configuration where all four leg codes appear together. Each code must also land on a leg whose index has a distinct bit pattern, so that a swapped select bit or a misplaced configuration field changes the visible result. The stimulus meets this with two hand-built words that place every code at both odd and even leg positions. After each word is loaded, all sixteen variable patterns are swept and compared with a truth table written down beforehand. Seeded random words are then added and checked against a reference computed from the leg coding rules.

// File: rtl/mxcell_pkg.sv
package mxcell_pkg;
  localparam int LEG_CODE_W = 2;

  typedef enum logic [LEG_CODE_W-1:0] {
    LEG_ZERO = 2'b00,
    LEG_ONE  = 2'b01,
    LEG_DATA = 2'b10,
    LEG_INV  = 2'b11
  } leg_code_e;
endpackage

// File: rtl/mxcell_rst_sync.sv
module mxcell_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic stage_d;
  logic out_d;

  always_comb begin
    stage_d = 1'b1;
    out_d   = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= stage_d;
      rst_sync_n <= out_d;
    end
  end
endmodule

// File: rtl/mxcell_cfg_reg.sv
module mxcell_cfg_reg #(
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_sync_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] cfg_q
);
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
    end
  end
endmodule

// File: rtl/mxcell_leg_src.sv
module mxcell_leg_src
  import mxcell_pkg::*;
(
  input  logic [LEG_CODE_W-1:0] code,
  input  logic                  data_bit,
  output logic                  leg_val
);
  always_comb begin
    case (leg_code_e'(code))
      LEG_ZERO: leg_val = 1'b0;
      LEG_ONE:  leg_val = 1'b1;
      LEG_DATA: leg_val = data_bit;
      LEG_INV:  leg_val = ~data_bit;
      default:  leg_val = 1'b0;
    endcase
  end
endmodule

// File: rtl/mxcell_mux_tree.sv
module mxcell_mux_tree #(
  parameter int SEL_W = 3,
  localparam int LEGS = 1 << SEL_W
) (
  input  logic [LEGS-1:0]  legs,
  input  logic [SEL_W-1:0] sel,
  output logic             y
);
  // stage[l] holds LEGS>>l live nodes; level l picks by sel[l]
  logic [SEL_W:0][LEGS-1:0] stage;

  assign stage[0] = legs;

  for (genvar l = 0; l < SEL_W; l++) begin : g_lvl
    localparam int NODES = LEGS >> (l + 1);
    for (genvar i = 0; i < LEGS; i++) begin : g_node
      if (i < NODES) begin : g_live
        assign stage[l+1][i] = sel[l] ? stage[l][2*i+1] : stage[l][2*i];
      end else begin : g_pad
        assign stage[l+1][i] = 1'b0;
      end
    end
  end

  assign y = stage[SEL_W][0];
endmodule

// File: rtl/mxcell_top.sv
module mxcell_top
  import mxcell_pkg::*;
#(
  parameter int NVARS = 4,
  localparam int SEL_W = NVARS - 1,
  localparam int LEGS  = 1 << SEL_W,
  localparam int CFG_W = LEG_CODE_W * LEGS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [NVARS-1:0] vars_in,
  input  logic             en,
  output logic             f_out
);
  logic             rst_sync_n;
  logic [CFG_W-1:0] cfg_q;
  logic [LEGS-1:0]  leg_val;
  logic             tree_y;

  mxcell_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mxcell_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .wr_en      (cfg_we),
    .wr_data    (cfg_wdata),
    .cfg_q      (cfg_q)
  );

  for (genvar k = 0; k < LEGS; k++) begin : g_leg
    mxcell_leg_src u_src (
      .code     (cfg_q[LEG_CODE_W*k +: LEG_CODE_W]),
      .data_bit (vars_in[0]),
      .leg_val  (leg_val[k])
    );
  end

  mxcell_mux_tree #(.SEL_W(SEL_W)) u_tree (
    .legs (leg_val),
    .sel  (vars_in[NVARS-1:1]),
    .y    (tree_y)
  );

  assign f_out = en & tree_y;
endmodule

// File: rtl/mxcell_chk.sv
module mxcell_chk #(
  parameter int NVARS = 4,
  localparam int SEL_W = NVARS - 1,
  localparam int CFG_W = 2 * (1 << SEL_W)
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic [CFG_W-1:0] cfg_q,
  input logic [NVARS-1:0] vars_in,
  input logic             en,
  input logic             f_out
);
  logic [1:0] cur_leg;
  assign cur_leg = cfg_q[{vars_in[NVARS-1:1], 1'b0} +: 2];

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> (cfg_q == '0));

  p_zero_leg_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && cur_leg == 2'b00) |-> !f_out);

  p_one_leg_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && cur_leg == 2'b01) |-> f_out);

  p_data_leg_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && cur_leg == 2'b10) |-> (f_out == vars_in[0]));

  p_inv_leg_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && cur_leg == 2'b11) |-> (f_out == !vars_in[0]));

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_we |=> (cfg_q == $past(cfg_wdata)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_we |=> $stable(cfg_q));

  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en |-> !f_out);
endmodule

bind mxcell_top mxcell_chk #(.NVARS(NVARS)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cfg_we     (cfg_we),
  .cfg_wdata  (cfg_wdata),
  .cfg_q      (cfg_q),
  .vars_in    (vars_in),
  .en         (en),
  .f_out      (f_out)
);

// File: tb/tb_mxcell_top.sv
module tb_mxcell_top;
  localparam int NVARS = 4;
  localparam int CFG_W = 16;
  localparam int NVEC  = 6;
  localparam int NRAND = 20;

  // {configuration word, expected truth table bit v for vars_in == v}
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h0000, 16'h0000},   // R2 all constant 0
    {16'h5555, 16'hFFFF},   // R3 all constant 1
    {16'hAAAA, 16'hAAAA},   // R4 all data
    {16'hFFFF, 16'h5555},   // R5 all inverted data
    {16'hE439, 16'h6C1B},   // R6 mixed codes
    {16'h8D27, 16'h872D}    // R6 mixed codes, other placement
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_we;
  logic [CFG_W-1:0] cfg_wdata;
  logic [NVARS-1:0] vars_in;
  logic             en;
  logic             f_out;

  int checks = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mxcell_top #(.NVARS(NVARS)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .vars_in   (vars_in),
    .en        (en),
    .f_out     (f_out)
  );

  function automatic logic ref_f(logic [CFG_W-1:0] cfg, logic [NVARS-1:0] v, logic e);
    logic [1:0] c;
    logic r;
    c = cfg[2*int'(v[NVARS-1:1]) +: 2];
    case (c)
      2'b00: r = 1'b0;
      2'b01: r = 1'b1;
      2'b10: r = v[0];
      default: r = ~v[0];
    endcase
    return e & r;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s vars=%0h actual=%0b expected=%0b", req, vars_in, act, exp);
    end
  endtask

  task automatic write_cfg(logic [CFG_W-1:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_wdata = ~w;
  endtask

  // R9: vars change with no clock edge between change and sample
  task automatic sweep_tt(string req, logic [15:0] tt);
    for (int v = 0; v < 16; v++) begin
      vars_in = v[NVARS-1:0];
      #0.5;
      check(req, f_out, tt[v]);
    end
  endtask

  task automatic sweep_ref(string req, logic [CFG_W-1:0] w);
    for (int v = 0; v < 16; v++) begin
      vars_in = v[NVARS-1:0];
      #0.5;
      check(req, f_out, ref_f(w, v[NVARS-1:0], en));
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [CFG_W-1:0] w;
    rst_n = 1'b0;
    cfg_we = 1'b0;
    cfg_wdata = '0;
    vars_in = '0;
    en = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs 0 while reset is held
    sweep_tt("R1 in reset", 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    sweep_tt("R1 after release", 16'h0000);

    // table walk: R2 R3 R4 R5 R6 R9
    for (int i = 0; i < NVEC; i++) begin
      write_cfg(VEC[i][31:16]);
      sweep_tt("R2-5/R6 table", VEC[i][15:0]);
    end

    // R7: strobe low with new data leaves the function unchanged
    @(negedge clk);
    cfg_wdata = 16'h1234;
    repeat (2) @(negedge clk);
    sweep_tt("R7 hold", 16'h872D);

    // R8: enable low gates, enable high restores the same function
    en = 1'b0;
    sweep_tt("R8 gated", 16'h0000);
    @(negedge clk);
    en = 1'b1;
    sweep_tt("R8 restored", 16'h872D);

    // R6: random words against the reference model
    for (int i = 0; i < NRAND; i++) begin
      w = CFG_W'($urandom());
      write_cfg(w);
      sweep_ref("R6 random", w);
    end

    // R1: reset after a load clears the function again
    write_cfg(16'h5555);
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    sweep_tt("R1 reset clears", 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    sweep_tt("R1 clear after release", 16'h0000);

    finish_run();
  end
endmodule